// File: doc/BRIEF.md
# IO Bank Freeze Sequencer

This block steps the pad-control lines of a group of general-purpose IO channels into and out of a frozen state. A single-cycle freeze or thaw request, together with a channel number, starts a fixed sequence that changes a subset of that channel's active-low controls at each step. Between steps the block holds for a minimum settle time. The settle time is turned into a whole number of clock cycles from two parameters: the settle time and the clock period.

A freeze is done in two steps. First the slew-enable, weak-pullup and tristate controls go low together. Then the bus-hold and config-done controls go low. A thaw is done in three steps. First bus-hold and config-done go high. Then weak-pullup and tristate go high. Finally slew-enable goes high. Channel numbers outside the implemented range are refused, and an error flag reports the refusal. While a sequence runs, `busy` is high and new requests are dropped. A one-cycle `done` pulse marks the final step.

Top module: `io_freeze_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every control output of every channel is 1, and busy, done and err are 0.
- R2: A freeze request accepted at edge E0 drives slew_n, pullup_n and tristate_n of the selected channel to 0 at that same edge, and busy reads 1 from E0.
- R3: At edge E0+W of a freeze, bushold_n and cfgdone_n of the channel go to 0. At the same edge busy falls and done rises, and done falls again one cycle later.
- R4: A thaw request accepted at edge E0 drives bushold_n and cfgdone_n of the selected channel to 1 at that edge, and busy reads 1 from E0.
- R5: At edge E0+W of a thaw, pullup_n and tristate_n of the channel go to 1, and busy stays 1.
- R6: At edge E0+2W of a thaw, slew_n goes to 1. At the same edge busy falls and done pulses for one cycle.
- R7: W is HOLD_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of 1. The defaults (20000 ps, 4000 ps) give W = 5. No control changes during the W-1 cycles between steps.
- R8: A request with ch_sel of 3 (at or above NUM_CH) raises err for exactly the next cycle. It changes no control output and does not raise busy.
- R9: A freeze or thaw request made while busy is 1 is ignored. The running sequence and all outputs continue as if no request had been made.
- R10: Bit i of each control vector belongs to channel i (ch_sel = i). Only the selected channel's bits change during a sequence.
- R11: If freeze_req and thaw_req are both 1 in the same idle cycle, the freeze is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze_req | input | 1 | Start a freeze sequence (sampled when idle) |
| thaw_req | input | 1 | Start a thaw sequence (sampled when idle) |
| ch_sel | input | 2 | Channel number for the request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the final step |
| err | output | 1 | One-cycle pulse after a refused channel number |
| slew_n | output | 3 | Active-low slew-enable control, one bit per channel |
| pullup_n | output | 3 | Active-low weak-pullup control, one bit per channel |
| tristate_n | output | 3 | Active-low tristate control, one bit per channel |
| bushold_n | output | 3 | Active-low bus-hold control, one bit per channel |
| cfgdone_n | output | 3 | Active-low config-done control, one bit per channel |

## Verification
A wrong phase or a miscounted hold timer shows up at the ports within one step interval (W cycles). It appears as a step edge that comes early or late, as busy falling at the wrong edge, or as done appearing after the wrong step. A corrupted captured channel number shows up as the step being applied to the wrong bit lane, and this is visible at the very next step. The bench compares the full set of outputs against its own model in every cycle of every sequence. Any of these faults therefore fails within a few cycles of the request that exposes it.

// File: rtl/frzseq_pkg.sv
// Package: shared types and the hold-time conversion for the freeze sequencer.
// Assumes: times are given in picoseconds as positive integers.
package frzseq_pkg;

    // Which step the controller asks the pad bank to apply this cycle.
    typedef enum logic [2:0] {
        STEP_NONE,
        STEP_FRZ_A,
        STEP_FRZ_B,
        STEP_THW_A,
        STEP_THW_B,
        STEP_THW_C
    } step_e;

    // Controller phase.
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HOLD1,
        PH_HOLD2
    } phase_e;

    // Rounded-up cycle count covering hold_ps, never less than one.
    function automatic int hold_cycles(input int hold_ps, input int clk_ps);
        int c;
        c = (hold_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/frzseq_timer.sv
// Module: down-counter that flags the last cycle of a hold window.
// Assumes: load and expire may coincide; load wins and restarts the window.
module frzseq_timer #(
    parameter int WAIT_CYC = 5,
    localparam int CNT_W = $clog2(WAIT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    logic [CNT_W-1:0] cnt;

    // Reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CNT_W'(WAIT_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/frzseq_ctrl.sv
// Module: phase controller; accepts requests, checks the channel, paces steps.
// Assumes: requests are sampled only in the idle phase; freeze wins over thaw.
module frzseq_ctrl
    import frzseq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            freeze_req,
    input  logic            thaw_req,
    input  logic [CH_W-1:0] ch_sel,
    input  logic            expire,
    output logic            load,
    output step_e           step,
    output logic [CH_W-1:0] act_ch,
    output logic            busy,
    output logic            done,
    output logic            err
);
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    phase_e          phase;
    logic            op_frz;
    logic [CH_W-1:0] ch_q;
    logic            req, ch_ok, accept, reject, finish;

    // Decode request acceptance and the step to apply this cycle.
    always_comb begin
        req    = freeze_req | thaw_req;
        ch_ok  = (ch_sel <= LAST_CH);
        accept = (phase == PH_IDLE) && req && ch_ok;
        reject = (phase == PH_IDLE) && req && !ch_ok;
        step   = STEP_NONE;
        finish = 1'b0;
        load   = 1'b0;
        act_ch = ch_q;
        unique case (phase)
            PH_IDLE: begin
                act_ch = ch_sel;
                if (accept) begin
                    step = freeze_req ? STEP_FRZ_A : STEP_THW_A;
                    load = 1'b1;
                end
            end
            PH_HOLD1: begin
                if (expire) begin
                    step   = op_frz ? STEP_FRZ_B : STEP_THW_B;
                    finish = op_frz;
                    load   = !op_frz;
                end
            end
            PH_HOLD2: begin
                if (expire) begin
                    step   = STEP_THW_C;
                    finish = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Advance the phase and register the status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            op_frz <= 1'b0;
            ch_q   <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= finish;
            err  <= reject;
            unique case (phase)
                PH_IDLE: if (accept) begin
                    phase  <= PH_HOLD1;
                    op_frz <= freeze_req;
                    ch_q   <= ch_sel;
                end
                PH_HOLD1: if (expire) phase <= op_frz ? PH_IDLE : PH_HOLD2;
                PH_HOLD2: if (expire) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);

    // R3 / R6: done is a single-cycle pulse.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: a refusal never coincides with a running sequence.
    a_r8_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R9: a new request while busy does not restart or end the sequence early.
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> busy);

endmodule

// File: rtl/frzseq_pad_bank.sv
// Module: per-channel control registers, updated by the step the controller applies.
// Assumes: at most one channel is stepped per cycle; all controls reset high.
module frzseq_pad_bank
    import frzseq_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic [CH_W-1:0]   act_ch,
    output logic [NUM_CH-1:0] slew_n,
    output logic [NUM_CH-1:0] pullup_n,
    output logic [NUM_CH-1:0] tristate_n,
    output logic [NUM_CH-1:0] bushold_n,
    output logic [NUM_CH-1:0] cfgdone_n
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = (act_ch == CH_W'(i));

        // Apply the requested step to this channel's five controls.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slew_n[i]     <= 1'b1;
                pullup_n[i]   <= 1'b1;
                tristate_n[i] <= 1'b1;
                bushold_n[i]  <= 1'b1;
                cfgdone_n[i]  <= 1'b1;
            end else if (hit) begin
                unique case (step)
                    STEP_FRZ_A: begin
                        slew_n[i]     <= 1'b0;
                        pullup_n[i]   <= 1'b0;
                        tristate_n[i] <= 1'b0;
                    end
                    STEP_FRZ_B: begin
                        bushold_n[i]  <= 1'b0;
                        cfgdone_n[i]  <= 1'b0;
                    end
                    STEP_THW_A: begin
                        bushold_n[i]  <= 1'b1;
                        cfgdone_n[i]  <= 1'b1;
                    end
                    STEP_THW_B: begin
                        pullup_n[i]   <= 1'b1;
                        tristate_n[i] <= 1'b1;
                    end
                    STEP_THW_C: slew_n[i] <= 1'b1;
                    default: ;
                endcase
            end
        end

        // R3: bus-hold only falls once the first freeze group is already low.
        a_r3_freeze_order: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bushold_n[i]) |-> (!slew_n[i] && !pullup_n[i] && !tristate_n[i]));
        // R6: slew-enable only rises once every other control is back high.
        a_r6_thaw_order: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(slew_n[i]) |-> (pullup_n[i] && tristate_n[i] && bushold_n[i] && cfgdone_n[i]));
    end

endmodule

// File: rtl/io_freeze_seq.sv
// Module: top of the IO bank freeze sequencer.
// Assumes: freeze_req / thaw_req are single-cycle pulses in the clk domain;
//          CLK_PERIOD_PS matches the real clock so the hold is honoured.
module io_freeze_seq
    import frzseq_pkg::*;
#(
    parameter int NUM_CH        = 3,
    parameter int CH_W          = 2,
    parameter int HOLD_PS       = 20000,
    parameter int CLK_PERIOD_PS = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze_req,
    input  logic              thaw_req,
    input  logic [CH_W-1:0]   ch_sel,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [NUM_CH-1:0] slew_n,
    output logic [NUM_CH-1:0] pullup_n,
    output logic [NUM_CH-1:0] tristate_n,
    output logic [NUM_CH-1:0] bushold_n,
    output logic [NUM_CH-1:0] cfgdone_n
);
    localparam int WAIT_CYC = hold_cycles(HOLD_PS, CLK_PERIOD_PS);

    logic            load, expire;
    step_e           step;
    logic [CH_W-1:0] act_ch;

    frzseq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .expire(expire)
    );

    frzseq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
        .ch_sel(ch_sel), .expire(expire), .load(load), .step(step),
        .act_ch(act_ch), .busy(busy), .done(done), .err(err)
    );

    frzseq_pad_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .step(step), .act_ch(act_ch),
        .slew_n(slew_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
        .bushold_n(bushold_n), .cfgdone_n(cfgdone_n)
    );

    // R8: a refused request leaves every control unchanged.
    a_r8_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(slew_n) && $stable(pullup_n) && $stable(tristate_n)
                 && $stable(bushold_n) && $stable(cfgdone_n)));

endmodule

// File: tb/sim_io_freeze_seq.sv
`timescale 1ns/1ps
module sim_io_freeze_seq;
    localparam int W = (20000 + 4000 - 1) / 4000;   // R7: ceil(20 ns / 4 ns) = 5

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freeze_req = 1'b0;
    logic       thaw_req = 1'b0;
    logic [1:0] ch_sel = 2'd0;
    logic       busy, done, err;
    logic [2:0] slew_n, pullup_n, tristate_n, bushold_n, cfgdone_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [2:0] e_sl, e_pu, e_ts, e_bh, e_cd;

    always #2 clk = ~clk;   // 250 MHz

    io_freeze_seq u0 (
        .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req), .thaw_req(thaw_req),
        .ch_sel(ch_sel), .busy(busy), .done(done), .err(err),
        .slew_n(slew_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
        .bushold_n(bushold_n), .cfgdone_n(cfgdone_n)
    );

    function automatic logic [17:0] pack_exp(input logic b, input logic d, input logic e,
                                             input logic [2:0] sl, input logic [2:0] pu,
                                             input logic [2:0] ts, input logic [2:0] bh,
                                             input logic [2:0] cd);
        return {sl, pu, ts, bh, cd, b, d, e};
    endfunction

    task automatic check(input string tag, input logic b, input logic d, input logic e);
        logic [17:0] act, exp;
        act = {slew_n, pullup_n, tristate_n, bushold_n, cfgdone_n, busy, done, err};
        exp = pack_exp(b, d, e, e_sl, e_pu, e_ts, e_bh, e_cd);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b (sl pu ts bh cd busy done err)", tag, act, exp);
        end
    endtask

    // One request; poke adds a conflicting request while busy (R9).
    task automatic run_op(input bit f, input bit t, input int ch, input bit poke);
        freeze_req = f; thaw_req = t; ch_sel = 2'(ch);
        @(negedge clk);
        freeze_req = 1'b0; thaw_req = 1'b0;
        if (!f && !t) begin
            check("R1 idle no request", 1'b0, 1'b0, 1'b0);
            return;
        end
        if (ch > 2) begin
            check("R8 refused channel err pulse", 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            check("R8 err single cycle", 1'b0, 1'b0, 1'b0);
            return;
        end
        if (f) begin
            e_sl[ch] = 1'b0; e_pu[ch] = 1'b0; e_ts[ch] = 1'b0;
            check(t ? "R11 freeze wins, R2 step1" : "R2 freeze step1 R10", 1'b1, 1'b0, 1'b0);
        end else begin
            e_bh[ch] = 1'b1; e_cd[ch] = 1'b1;
            check("R4 thaw step1 R10", 1'b1, 1'b0, 1'b0);
        end
        for (int k = 1; k < W; k++) begin
            if (poke && k == 1) begin
                freeze_req = !f; thaw_req = f; ch_sel = 2'((ch + 1) % 3);
            end
            @(negedge clk);
            freeze_req = 1'b0; thaw_req = 1'b0;
            check("R7 hold window R9", 1'b1, 1'b0, 1'b0);
        end
        @(negedge clk);
        if (f) begin
            e_bh[ch] = 1'b0; e_cd[ch] = 1'b0;
            check("R3 freeze step2 done", 1'b0, 1'b1, 1'b0);
        end else begin
            e_pu[ch] = 1'b1; e_ts[ch] = 1'b1;
            check("R5 thaw step2", 1'b1, 1'b0, 1'b0);
            for (int k = 1; k < W; k++) begin
                @(negedge clk);
                check("R7 second hold window", 1'b1, 1'b0, 1'b0);
            end
            @(negedge clk);
            e_sl[ch] = 1'b1;
            check("R6 thaw step3 done", 1'b0, 1'b1, 1'b0);
        end
        @(negedge clk);
        check("R3 R6 done single pulse", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        e_sl = '1; e_pu = '1; e_ts = '1; e_bh = '1; e_cd = '1;
        repeat (3) @(negedge clk);
        check("R1 outputs during reset", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0, 1'b0);

        // Directed corners.
        run_op(1, 0, 3, 0);   // R8 refused freeze
        run_op(1, 0, 0, 0);   // R2/R3
        run_op(0, 1, 3, 0);   // R8 refused thaw
        run_op(1, 1, 1, 0);   // R11 both at once
        run_op(1, 0, 2, 1);   // R9 poke during freeze
        run_op(0, 1, 0, 1);   // R9 poke during thaw
        run_op(0, 1, 1, 0);   // R5/R6
        run_op(0, 1, 2, 0);

        // Constrained random mix.
        for (int n = 0; n < 60; n++) begin
            int r, c;
            bit p;
            r = $urandom % 8;
            c = $urandom % 4;
            p = 1'($urandom % 2);
            if (r < 3)      run_op(1, 0, c, p);
            else if (r < 6) run_op(0, 1, c, p);
            else if (r == 6) run_op(1, 1, c, p);
            else            run_op(0, 0, c, 0);
        end

        // Reset from a frozen state returns everything high.
        run_op(1, 0, 1, 0);
        rst_n = 1'b0;
        @(negedge clk);
        e_sl = '1; e_pu = '1; e_ts = '1; e_bh = '1; e_cd = '1;
        check("R1 reset after freeze", 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule